// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block holds the programming word of a frequency synthesizer. The word has three fields: a 9-bit feedback divide value, a 2-bit output divider select and a 2-bit test select. The word can be written in two ways that share the same register. The first is a parallel pin path governed by a load strobe. The second is a serial shift path with its own clock, data and load strobe. A serial event always overrides a value held by the parallel path.

Every strobe, serial pin and parallel data pin is asynchronous to the fast system clock. Each one passes through a two-flop synchronizer before any edge is detected from it. The block also steers a test output from one of four sources, chosen by the test-select field. A held master-reset input silences the test output and freezes the word. Power-on reset is a separate synchronous input, `rst_n`.

Top module: `divcfg_loader`

## Requirements
- R1: While `rst_n` is low at a clock edge, the settings take M=25, N=0 and T=0, and `cfg_upd` is low. After release the settings stay there until a load path acts. `pload` idles high.
- R2: While the synchronized `pload` is low, `pm_in`/`pn_in` flow into `cfg_m`/`cfg_n`. A pin change is visible on the outputs three clock edges later: two synchronizer stages plus one register.
- R3: On a low-to-high edge of `pload`, the settings capture the pin values. They then ignore the pins while `pload` stays high.
- R4: While `pload` is high, each rising `sclk` edge shifts `sdat` into a 13-bit register, first bit first. After 13 shifts, bits [12:11] hold T, [10:9] hold N and [8:0] hold M. While `sload` stays low, shifting alone leaves the settings unchanged.
- R5: A rising `sload` copies the whole shift register into T, N and M. The falling edge of `sload` leaves them as they are.
- R6: While `sload` is held high, each rising `sclk` edge both shifts and copies the new register contents into the settings.
- R7: In serial mode (`pload` high, `mreset` low), `test_out` follows T. The code 00 gives low, 01 gives the synchronized `sdat`, 10 gives `fbdiv_in` and 11 gives `oclk_in`.
- R8: While the synchronized `pload` is low, `test_out` is low.
- R9: While the synchronized `mreset` is high, `test_out` is low, the settings do not change, and no load or shift takes effect.
- R10: `cfg_upd` is high for exactly the cycle in which a changed setting first appears on the outputs, and low otherwise.
- R11: `m_range_err` is high exactly when `cfg_m` is below 25 or above 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| mreset | input | 1 | Master reset, active high, asynchronous |
| pload | input | 1 | Parallel load strobe, asynchronous |
| pm_in | input | 9 | Parallel feedback divide value |
| pn_in | input | 2 | Parallel output divider select |
| sclk | input | 1 | Serial shift clock, asynchronous |
| sdat | input | 1 | Serial data |
| sload | input | 1 | Serial load strobe |
| fbdiv_in | input | 1 | Feedback divider output, test source |
| oclk_in | input | 1 | Logic-level copy of output clock, test source |
| test_out | output | 1 | Test output |
| cfg_m | output | 9 | Active feedback divide value |
| cfg_n | output | 2 | Active output divider select |
| cfg_t | output | 2 | Active test select |
| cfg_upd | output | 1 | One-cycle pulse on any settings change |
| m_range_err | output | 1 | Active M outside the lockable range |

## Verification
The parallel path is driven through three patterns:
- Changing pins under a low strobe, which shows the path is transparent.
- Pins that change together with the rising strobe, which shows the capture value.
- Pins that change after the strobe rises, which shows the hold.

The serial path is driven through three patterns:
- A shift with the load strobe low, to show the settings do not move.
- A pulsed load strobe, to show the word copy.
- A load strobe held high across a full word, which separates the pass-through mode from the pulsed copy.

Each test-select code is tried with its source toggled, and master reset is applied while the parallel pins change. A behavioural model in the bench checks every output on every cycle.

// File: rtl/divcfg_pkg.sv
// Shared widths and types for the divider configuration loader.
package divcfg_pkg;
    localparam int M_W    = 9;
    localparam int N_W    = 2;
    localparam int T_W    = 2;
    localparam int WORD_W = T_W + N_W + M_W;

    // Field order matches serial arrival: T first, M last.
    typedef struct packed {
        logic [T_W-1:0] t;
        logic [N_W-1:0] n;
        logic [M_W-1:0] m;
    } cfg_word_t;

    typedef enum logic [T_W-1:0] {
        TSEL_LOW   = 2'b00,
        TSEL_SDATA = 2'b01,
        TSEL_FBDIV = 2'b10,
        TSEL_OCLK  = 2'b11
    } tsel_e;
endpackage

// File: rtl/divcfg_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent or quasi-static, so no bus coherence is needed.
module divcfg_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // first stage samples the raw pins
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= d;
            end
        end else begin : g_next
            // later stages settle metastability
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/divcfg_regs.sv
// Settings register with its parallel and serial load paths, plus the shift register.
// Assumes all inputs are already synchronized to clk. A parallel-mode cycle is one
// where pload is low or has just risen. Serial actions need pload high on two samples.
module divcfg_regs
    import divcfg_pkg::*;
#(
    parameter cfg_word_t RST_CFG = '{t: '0, n: '0, m: M_W'(25)}
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pl_s,
    input  logic            sl_s,
    input  logic            sc_s,
    input  logic            sd_s,
    input  logic            mr_s,
    input  logic [M_W-1:0]  pm_s,
    input  logic [N_W-1:0]  pn_s,
    output cfg_word_t       cfg,
    output logic            upd,
    output logic            pl_prev,
    output logic            sl_prev
);
    logic [WORD_W-1:0] shreg, shreg_nxt;
    cfg_word_t         cfg_nxt;
    logic              sc_prev;
    logic              sc_rise, sl_rise, par_mode;

    assign sc_rise  = sc_s & ~sc_prev;
    assign sl_rise  = sl_s & ~sl_prev;
    assign par_mode = ~pl_s | ~pl_prev;

    // next settings and shift contents from the two load paths
    always_comb begin
        cfg_nxt   = cfg;
        shreg_nxt = shreg;
        if (!mr_s) begin
            if (par_mode) begin
                cfg_nxt.m = pm_s;
                cfg_nxt.n = pn_s;
            end else begin
                if (sc_rise) shreg_nxt = {shreg[WORD_W-2:0], sd_s};
                if (sl_rise)              cfg_nxt = cfg_word_t'(shreg);
                else if (sl_s && sc_rise) cfg_nxt = cfg_word_t'(shreg_nxt);
            end
        end
    end

    // previous synchronized strobes for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pl_prev <= 1'b1;
            sl_prev <= 1'b0;
            sc_prev <= 1'b0;
        end else begin
            pl_prev <= pl_s;
            sl_prev <= sl_s;
            sc_prev <= sc_s;
        end
    end

    // settings, shift register and change pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg   <= RST_CFG;
            shreg <= '0;
            upd   <= 1'b0;
        end else begin
            cfg   <= cfg_nxt;
            shreg <= shreg_nxt;
            upd   <= (cfg_nxt != cfg);
        end
    end
endmodule

// File: rtl/divcfg_testmux.sv
// Test output selector. Assumes the sources are plain logic signals; the output is
// forced low when en is low.
module divcfg_testmux
    import divcfg_pkg::*;
(
    input  logic           en,
    input  logic [T_W-1:0] sel,
    input  logic           sd,
    input  logic           fb,
    input  logic           oclk,
    output logic           y
);
    // pick the source named by the test select
    always_comb begin
        y = 1'b0;
        if (en) begin
            unique case (tsel_e'(sel))
                TSEL_LOW:   y = 1'b0;
                TSEL_SDATA: y = sd;
                TSEL_FBDIV: y = fb;
                TSEL_OCLK:  y = oclk;
                default:    y = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/divcfg_loader.sv
// Top of the divider configuration loader. It synchronizes every asynchronous pin,
// runs both load paths into one settings register, flags an M out of lock range and
// drives the test output. Assumes clk runs well above the serial clock rate.
module divcfg_loader
    import divcfg_pkg::*;
#(
    parameter int             SYNC_STAGES = 2,
    parameter int             M_LO        = 25,
    parameter int             M_HI        = 31,
    parameter logic [M_W-1:0] RST_M       = 9'd25,
    parameter logic [N_W-1:0] RST_N       = 2'd0,
    parameter logic [T_W-1:0] RST_T       = 2'd0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           mreset,
    input  logic           pload,
    input  logic [M_W-1:0] pm_in,
    input  logic [N_W-1:0] pn_in,
    input  logic           sclk,
    input  logic           sdat,
    input  logic           sload,
    input  logic           fbdiv_in,
    input  logic           oclk_in,
    output logic           test_out,
    output logic [M_W-1:0] cfg_m,
    output logic [N_W-1:0] cfg_n,
    output logic [T_W-1:0] cfg_t,
    output logic           cfg_upd,
    output logic           m_range_err
);
    localparam int              SYNC_W   = 5 + M_W + N_W;
    localparam int              PL_BIT   = M_W + N_W;
    localparam logic [SYNC_W-1:0] SYNC_RST = SYNC_W'(1) << PL_BIT;

    logic [SYNC_W-1:0] raw, syn;
    logic              mr_s, sd_s, sc_s, sl_s, pl_s;
    logic [N_W-1:0]    pn_s;
    logic [M_W-1:0]    pm_s;
    logic              pl_q, sl_q;
    cfg_word_t         cfg;

    assign raw = {mreset, sdat, sclk, sload, pload, pn_in, pm_in};
    assign {mr_s, sd_s, sc_s, sl_s, pl_s, pn_s, pm_s} = syn;

    divcfg_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(raw), .q(syn)
    );

    divcfg_regs #(.RST_CFG('{t: RST_T, n: RST_N, m: RST_M})) u_regs (
        .clk(clk), .rst_n(rst_n),
        .pl_s(pl_s), .sl_s(sl_s), .sc_s(sc_s), .sd_s(sd_s), .mr_s(mr_s),
        .pm_s(pm_s), .pn_s(pn_s),
        .cfg(cfg), .upd(cfg_upd), .pl_prev(pl_q), .sl_prev(sl_q)
    );

    divcfg_testmux u_tmux (
        .en(pl_s & ~mr_s), .sel(cfg.t), .sd(sd_s), .fb(fbdiv_in), .oclk(oclk_in),
        .y(test_out)
    );

    assign cfg_m       = cfg.m;
    assign cfg_n       = cfg.n;
    assign cfg_t       = cfg.t;
    assign m_range_err = (cfg.m < M_W'(M_LO)) || (cfg.m > M_W'(M_HI));
endmodule

// File: rtl/divcfg_loader_chk.sv
// Property checker for divcfg_loader, attached by bind below.
module divcfg_loader_chk #(
    parameter logic [8:0] RST_M = 9'd25,
    parameter logic [1:0] RST_N = 2'd0,
    parameter logic [1:0] RST_T = 2'd0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       pl_s,
    input logic       pl_q,
    input logic       sl_s,
    input logic       sl_q,
    input logic       mr_s,
    input logic [8:0] cfg_m,
    input logic [1:0] cfg_n,
    input logic [1:0] cfg_t,
    input logic       cfg_upd,
    input logic       test_out
);
    // R1
    reset_defaults_chk: assert property (@(posedge clk)
        !rst_n |=> (cfg_m == RST_M && cfg_n == RST_N && cfg_t == RST_T && !cfg_upd));

    // R4
    shift_only_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pl_s && pl_q && !sl_s && !sl_q) |=> ($stable(cfg_m) && $stable(cfg_n) && $stable(cfg_t)));

    // R8
    par_test_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pl_s |-> !test_out);

    // R9
    mreset_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mr_s |=> ($stable(cfg_m) && $stable(cfg_n) && $stable(cfg_t) && !test_out));

    // R10
    change_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(cfg_m) && $stable(cfg_n) && $stable(cfg_t)) |-> cfg_upd);

    // R10
    no_idle_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(cfg_m) && $stable(cfg_n) && $stable(cfg_t)) |-> !cfg_upd);
endmodule

bind divcfg_loader divcfg_loader_chk #(.RST_M(RST_M), .RST_N(RST_N), .RST_T(RST_T)) u_chk (
    .clk(clk), .rst_n(rst_n), .pl_s(pl_s), .pl_q(pl_q), .sl_s(sl_s), .sl_q(sl_q),
    .mr_s(mr_s), .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_t(cfg_t), .cfg_upd(cfg_upd),
    .test_out(test_out)
);

// File: tb/divcfg_loader_bench.sv
module divcfg_loader_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0, mreset = 1'b0, pload = 1'b1;
    logic [8:0] pm_in = '0;
    logic [1:0] pn_in = '0;
    logic       sclk = 1'b0, sdat = 1'b0, sload = 1'b0, fbdiv_in = 1'b0, oclk_in = 1'b0;
    logic       test_out, cfg_upd, m_range_err;
    logic [8:0] cfg_m;
    logic [1:0] cfg_n, cfg_t;

    int    n_chk = 0, n_fail = 0;
    bit    started = 0, done = 0;
    string cur_req = "R1";

    always #4ns clk = ~clk;

    divcfg_loader u_divcfg_loader (
        .clk(clk), .rst_n(rst_n), .mreset(mreset), .pload(pload), .pm_in(pm_in),
        .pn_in(pn_in), .sclk(sclk), .sdat(sdat), .sload(sload), .fbdiv_in(fbdiv_in),
        .oclk_in(oclk_in), .test_out(test_out), .cfg_m(cfg_m), .cfg_n(cfg_n),
        .cfg_t(cfg_t), .cfg_upd(cfg_upd), .m_range_err(m_range_err)
    );

    // ---------------- behavioural reference model ----------------
    typedef struct packed {
        logic mr, sd, sc, sl, pl;
        logic [1:0] pn;
        logic [8:0] pm;
    } smp_t;
    localparam smp_t IDLE = '{mr: 0, sd: 0, sc: 0, sl: 0, pl: 1, pn: 0, pm: 0};

    smp_t        dq[$];
    smp_t        prv;
    logic [12:0] m_word = {2'd0, 2'd0, 9'd25};
    logic [12:0] m_sh = '0;
    logic        m_upd = 0;

    always @(posedge clk) begin
        smp_t        s;
        logic [12:0] nw, nsh;
        started = 1;
        if (!rst_n) begin
            m_word = {2'd0, 2'd0, 9'd25};
            m_sh   = '0;
            m_upd  = 0;
            dq     = '{IDLE, IDLE};
            prv    = IDLE;
        end else begin
            s  = dq[0];
            nw = m_word;
            if (!s.mr) begin
                if (!s.pl || !prv.pl) nw = {m_word[12:11], s.pn, s.pm};
                else begin
                    nsh = m_sh;
                    if (s.sc && !prv.sc) nsh = {m_sh[11:0], s.sd};
                    if (s.sl && !prv.sl) nw = m_sh;
                    else if (s.sl && s.sc && !prv.sc) nw = nsh;
                    m_sh = nsh;
                end
            end
            m_upd  = (nw != m_word);
            m_word = nw;
            prv    = s;
            void'(dq.pop_front());
            dq.push_back('{mr: mreset, sd: sdat, sc: sclk, sl: sload, pl: pload,
                           pn: pn_in, pm: pm_in});
        end
    end

    function automatic logic model_test();
        if (dq.size() < 1 || dq[0].mr || !dq[0].pl) return 1'b0;
        case (m_word[12:11])
            2'b01:   return dq[0].sd;
            2'b10:   return fbdiv_in;
            2'b11:   return oclk_in;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            chk({cur_req, " settings"}, {cfg_t, cfg_n, cfg_m}, m_word);
            chk({cur_req, " R10 update"}, cfg_upd, m_upd);
            chk({cur_req, " R11 range"}, m_range_err, (m_word[8:0] < 25 || m_word[8:0] > 31));
            chk({cur_req, " test_out"}, test_out, model_test());
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2ns;
    endtask

    task automatic shift_word(input logic [12:0] w);
        for (int i = 12; i >= 0; i--) begin
            sdat = w[i]; step(3);
            sclk = 1'b1; step(3);
            sclk = 1'b0; step(3);
        end
    endtask

    task automatic pulse_sload();
        sload = 1'b1; step(4);
        sload = 1'b0; step(4);
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        int cnt;
        step(4);
        rst_n = 1'b1; step(1);
        cur_req = "R1";
        chk("R1 reset M", cfg_m, 25); chk("R1 reset N", cfg_n, 0);
        chk("R1 reset T", cfg_t, 0);  chk("R1 reset upd", cfg_upd, 0);
        step(4);
        chk("R1 held M", cfg_m, 25);

        cur_req = "R2";
        pload = 0; pm_in = 27; pn_in = 2; step(5);
        chk("R2 transparent M", cfg_m, 27); chk("R2 transparent N", cfg_n, 2);
        pm_in = 100; step(5);
        chk("R2 follow M", cfg_m, 100); chk("R11 high M flag", m_range_err, 1);

        cur_req = "R3";
        pm_in = 30; pn_in = 1; pload = 1; step(5);
        chk("R3 capture M", cfg_m, 30); chk("R3 capture N", cfg_n, 1);
        chk("R11 in range", m_range_err, 0);
        pm_in = 5; pn_in = 3; step(6);
        chk("R3 hold M", cfg_m, 30); chk("R3 hold N", cfg_n, 1);

        cur_req = "R4";
        shift_word({2'b01, 2'b11, 9'h1A5});
        chk("R4 no change during shift", cfg_m, 30);
        cur_req = "R5";
        pulse_sload();
        chk("R5 load M", cfg_m, 9'h1A5); chk("R5 load N", cfg_n, 3); chk("R5 load T", cfg_t, 1);

        cur_req = "R7";
        sdat = 1; step(4); chk("R7 sdata source hi", test_out, 1);
        sdat = 0; step(4); chk("R7 sdata source lo", test_out, 0);
        shift_word({2'b10, 2'b00, 9'd28}); pulse_sload();
        fbdiv_in = 1; step(1); chk("R7 fbdiv source hi", test_out, 1);
        fbdiv_in = 0; step(1); chk("R7 fbdiv source lo", test_out, 0);
        shift_word({2'b11, 2'b10, 9'd29}); pulse_sload();
        oclk_in = 1; step(1); chk("R7 oclk source hi", test_out, 1);
        oclk_in = 0; step(1); chk("R7 oclk source lo", test_out, 0);
        shift_word({2'b00, 2'b00, 9'd27}); pulse_sload();
        oclk_in = 1; fbdiv_in = 1; sdat = 1; step(4);
        chk("R7 low source", test_out, 0);
        oclk_in = 0; fbdiv_in = 0; sdat = 0;

        cur_req = "R6";
        sload = 1; step(4);
        shift_word({2'b00, 2'b01, 9'd26});
        chk("R6 pass M", cfg_m, 26); chk("R6 pass N", cfg_n, 1); chk("R6 pass T", cfg_t, 0);
        sload = 0; step(4);
        chk("R5 fall keeps M", cfg_m, 26);

        cur_req = "R8";
        shift_word({2'b11, 2'b10, 9'd29}); pulse_sload();
        oclk_in = 1; step(1); chk("R8 pre serial test", test_out, 1);
        pload = 0; pm_in = 31; pn_in = 0; step(5);
        chk("R8 parallel forces low", test_out, 0); chk("R2 parallel M", cfg_m, 31);
        oclk_in = 0;

        cur_req = "R9";
        pload = 1; step(5);
        mreset = 1; step(4);
        pload = 0; pm_in = 7; step(6);
        chk("R9 M frozen", cfg_m, 31); chk("R9 test low", test_out, 0);
        pload = 1; step(4);
        mreset = 0; step(5);
        chk("R9 M after release", cfg_m, 31);

        cur_req = "R10";
        pload = 0; step(6);
        pm_in = 27; cnt = 0;
        for (int i = 0; i < 8; i++) begin step(1); cnt += int'(cfg_upd); end
        chk("R10 one pulse per change", cnt, 1);
        cnt = 0;
        for (int i = 0; i < 8; i++) begin step(1); cnt += int'(cfg_upd); end
        chk("R10 no pulse when idle", cnt, 0);
        pload = 1; step(4);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog R1..: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end
endmodule